// File: doc/BRIEF.md
# Serial Key Debug and Boot Unlock Controller

This block guards debug access and the choice of external boot behind a secret key. A test-access path shifts the key in one bit at a time. When an update strobe arrives, the block compares the captured value with a key fixed at build time. On an exact match it raises two enables, one for emulation and debug and one for external boot, and they stay high until the next system reset. On a mismatch nothing changes, and no partial unlock state exists.

While the block is locked, the external boot enable stays low and a companion output tells the boot logic to run only from internal memory. The serial output of the shift path is held at zero so that nothing shifted in can be read back. If the security enable input is tied low, the part is treated as unsecured, and both enables are active straight out of reset. Simple shift and update strobes take the place of the full test-access state machine.

Top module: `jtag_key_unlock`

## Requirements
- R1: Reset clears the key shift register to all zeros and puts the block in the locked state. With security enabled, both enables are low after reset.
- R2: On each cycle with `shift_en` high, the register takes `tdi` into its top bit and moves every bit one place toward bit 0, so the key goes in least significant bit first. Shifting alone never unlocks the block.
- R3: When `update` is high and the register equals `KEY` exactly, both `dbg_en` and `ext_boot_en` go high on the following cycle.
- R4: An `update` while the register differs from `KEY` in any bit leaves the block locked.
- R5: Once the block is unlocked, it stays unlocked until reset. A later update with a wrong key does not lock it again.
- R6: While `sec_en` is low, `dbg_en` and `ext_boot_en` are both high, whether or not a key has been entered.
- R7: While `sec_en` is high and the block is locked, `tdo` is 0. Otherwise `tdo` shows bit 0 of the shift register.
- R8: `int_boot_only` is high exactly when `ext_boot_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| sec_en | input | 1 | Security enable; low means the part is unsecured |
| shift_en | input | 1 | Shift strobe for the key register |
| tdi | input | 1 | Serial key data in |
| update | input | 1 | Update strobe; triggers the key comparison |
| tdo | output | 1 | Serial out; held at 0 while secured and locked |
| dbg_en | output | 1 | Emulation and debug access enable |
| ext_boot_en | output | 1 | External boot modes enable |
| int_boot_only | output | 1 | Boot logic must run only from internal memory |

## Verification
The bench builds the block with `KEY_W` = 8 and `KEY` = 8'hA5. At that size it can try every one of the 256 possible keys, each after a fresh reset, and confirm that exactly one of them unlocks. For the single matching value it also checks that unlocking needs the update strobe, that the unlock sticks through a later wrong key, and that `tdo` stays silent before the unlock and then shows shifted bits in order. A run with security disabled exposes the reset value of the register and the order in which bits pass through it.

// File: rtl/jtag_key_unlock.sv
module jtag_key_unlock #(
  parameter int unsigned     KEY_W = 64,
  parameter logic [KEY_W-1:0] KEY  = 64'h3C5A_9E17_D2B4_6F81
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_en,
  input  logic shift_en,
  input  logic tdi,
  input  logic update,
  output logic tdo,
  output logic dbg_en,
  output logic ext_boot_en,
  output logic int_boot_only
);

  logic [KEY_W-1:0] key_sr;
  logic             opened;
  logic             match;

  assign match = (key_sr == KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_sr <= '0;
    else if (shift_en) key_sr <= {tdi, key_sr[KEY_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) opened <= 1'b0;
    else if (update && match) opened <= 1'b1;
  end

  assign dbg_en        = opened | ~sec_en;
  assign ext_boot_en   = opened | ~sec_en;
  assign int_boot_only = ~ext_boot_en;
  assign tdo           = (sec_en & ~opened) ? 1'b0 : key_sr[0];

  a_r5_sticky_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    opened |=> opened);

  a_r3_unlock_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(opened) |-> ($past(update) && $past(key_sr) == KEY));

  a_r4_wrong_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!opened && update && key_sr != KEY) |=> !opened);

  a_r7_tdo_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_en && !dbg_en) |-> !tdo);

  a_r8_boot_source: assert property (@(posedge clk) disable iff (!rst_n)
    int_boot_only != ext_boot_en);

endmodule

// File: tb/jtag_key_unlock_tb_top.sv
module jtag_key_unlock_tb_top;
  localparam int unsigned W = 8;
  localparam logic [W-1:0] K = 8'hA5;

  logic clk = 1'b0, rst_n = 1'b0, sec_en = 1'b1, shift_en = 1'b0, tdi = 1'b0, update = 1'b0;
  logic tdo, dbg_en, ext_boot_en, int_boot_only;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  jtag_key_unlock #(.KEY_W(W), .KEY(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_en(sec_en), .shift_en(shift_en), .tdi(tdi),
    .update(update), .tdo(tdo), .dbg_en(dbg_en), .ext_boot_en(ext_boot_en),
    .int_boot_only(int_boot_only));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input logic s, input logic d, input logic u);
    @(negedge clk); shift_en = s; tdi = d; update = u;
    @(negedge clk); shift_en = 1'b0; update = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic load(input logic [W-1:0] v, input bit chk_silent);
    for (int i = 0; i < W; i++) begin
      pulse(1'b1, v[i], 1'b0);
      if (chk_silent) chk("R7 tdo zero while locked", tdo, 1'b0);
    end
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Unsecured run: reset value and bit order become visible on tdo
    sec_en = 1'b0;
    do_reset();
    chk("R6 dbg_en unsecured", dbg_en, 1'b1);
    chk("R6 ext_boot_en unsecured", ext_boot_en, 1'b1);
    chk("R8 int_boot_only unsecured", int_boot_only, 1'b0);
    for (int i = 0; i < W; i++) begin
      chk("R1 register clear after reset", tdo, 1'b0);
      pulse(1'b1, 1'b0, 1'b0);
    end
    load(8'h4D, 1'b0);
    for (int i = 0; i < W; i++) begin
      chk("R2 lsb-first order", tdo, 1'(8'h4D >> i));
      pulse(1'b1, 1'b0, 1'b0);
    end

    // Secured: sweep every key
    sec_en = 1'b1;
    for (int v = 0; v < 256; v++) begin
      do_reset();
      chk("R1 locked after reset", dbg_en, 1'b0);
      load(8'(v), 1'b1);
      chk("R2 no unlock without update", dbg_en, 1'b0);
      pulse(1'b0, 1'b0, 1'b1);
      chk(v == K ? "R3 match unlocks dbg" : "R4 wrong key ignored", dbg_en, v == K);
      chk(v == K ? "R3 match unlocks boot" : "R4 wrong key boot", ext_boot_en, v == K);
      chk("R8 int_boot_only", int_boot_only, v != K);
      if (v == K) begin
        load(8'h5A, 1'b0);
        pulse(1'b0, 1'b0, 1'b1);
        chk("R5 wrong key keeps unlock", dbg_en, 1'b1);
        chk("R5 boot stays enabled", ext_boot_en, 1'b1);
        for (int i = 0; i < W; i++) begin
          chk("R7 tdo shows bit 0 when unlocked", tdo, 1'(8'h5A >> i));
          pulse(1'b1, 1'b0, 1'b0);
        end
      end
    end

    // Reset relocks after an unlock
    do_reset();
    chk("R1 reset relocks", dbg_en, 1'b0);
    chk("R1 reset relocks boot", ext_boot_en, 1'b0);
    // Security dropped while locked: enables active without key
    sec_en = 1'b0;
    @(negedge clk);
    chk("R6 enables without key", dbg_en, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule